// File: doc/BRIEF.md
# Hardware Page Table Walker

This block services translation-cache misses without software help. When the translation cache reports a miss, the walker accepts the virtual page number and the kind of access that was attempted, together with the current page-table base. It forms the address of the single page-table entry that describes the page, and fetches that entry with one read over a simple request/response memory handshake.

It then judges the returned entry. A clear valid bit ends the walk with a segmentation fault. A valid entry whose permissions do not cover the attempted access ends with a protection fault. Any other entry is written into the translation cache through a one-cycle insert port, and the walk ends with a retry status that tells the requester to replay the access. Each walk finishes with a one-cycle completion strobe and a status code. Only one walk is in flight at a time, and new misses are held off until the current one completes.

Top module: `ptw_walker`

## Requirements
- R1: The entry address issued to memory is the page-table base plus the virtual page number shifted left by log2 of the entry size (4 bytes by default), modulo 2^PA_W. The base and the page number are sampled on the cycle the miss is accepted.
- R2: Each accepted miss causes exactly one memory read request. `rd_req_valid` and `rd_req_addr` stay unchanged until the cycle in which `rd_req_ready` is high.
- R3: If bit DATA_W-1 (valid) of the returned entry is 0, the walk ends with status 1 (segmentation fault) and no insert, whatever the permission bits hold.
- R4: If the entry is valid and any bit set in `miss_perm` is clear in the entry's permission field, the walk ends with status 2 (protection fault) and no insert.
- R5: Otherwise `ins_valid` pulses for one cycle carrying the page number, the entry's frame number and the entry's permission field, and the completion strobe follows in the next cycle with status 0 (retry).
- R6: `walk_done` is high for exactly one cycle per accepted miss, and `walk_status` is 0, 1 or 2 while it is high.
- R7: `miss_ready` is high only while the walker is idle. A miss offered while the walker is busy is not taken: it starts no read and produces no completion.
- R8: After reset `miss_ready` is 1 and `rd_req_valid`, `ins_valid` and `walk_done` are 0.
- R9: Entry layout: the valid bit is DATA_W-1, the permission field is bits DATA_W-2 down to DATA_W-4, and the frame number is bits PFN_W-1 down to 0. The bits in between are ignored. In both `miss_perm` and the permission field, bit 2 is read, bit 1 is write and bit 0 is execute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pt_base | input | PA_W | Page-table base address |
| miss_valid | input | 1 | Miss request present |
| miss_ready | output | 1 | Walker idle and taking a miss |
| miss_vpn | input | VPN_W | Virtual page number that missed |
| miss_perm | input | 3 | Access needed (read, write, execute) |
| rd_req_valid | output | 1 | Memory read request |
| rd_req_ready | input | 1 | Memory takes the request |
| rd_req_addr | output | PA_W | Entry address |
| rd_rsp_valid | input | 1 | Read data present |
| rd_rsp_data | input | DATA_W | Fetched page-table entry |
| ins_valid | output | 1 | Insert strobe toward translation cache |
| ins_vpn | output | VPN_W | Page number to insert |
| ins_pfn | output | PFN_W | Frame number to insert |
| ins_perm | output | 3 | Permission field to insert |
| walk_done | output | 1 | Walk finished (one cycle) |
| walk_status | output | 2 | 0 retry, 1 segmentation fault, 2 protection fault |

## Verification
Misses are driven with entries that are valid and permitting, invalid but carrying full permissions, and valid but lacking one needed right. Together these show that the valid check comes before the permission check and that faults never insert. Page numbers of zero, the maximum value and several bases show how the address is formed and where it wraps. Junk bits in the ignored middle field test the field boundaries. Memory stalls and response delays of several lengths show that the request is held and that only one read is made. A miss offered during a busy walk shows that the walker refuses it.

// File: rtl/ptw_pkg.sv
// Shared types for the page table walker.
// Assumes: status encodings are fixed by the requester's decoder.
package ptw_pkg;
    typedef enum logic [1:0] {
        WALK_RETRY = 2'd0,
        WALK_SEGV  = 2'd1,
        WALK_PROT  = 2'd2
    } walk_status_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ISSUE,
        S_WAIT,
        S_CHECK,
        S_INSERT,
        S_DONE
    } walk_state_e;
endpackage

// File: rtl/ptw_addr_gen.sv
// Forms a page-table entry address from base and page number.
// Assumes: ENTRY_BYTES > 0; a power of two becomes a shift, anything else a multiply.
module ptw_addr_gen #(
    parameter int PA_W        = 32,
    parameter int VPN_W       = 20,
    parameter int ENTRY_BYTES = 4
) (
    input  logic [PA_W-1:0]  base,
    input  logic [VPN_W-1:0] vpn,
    output logic [PA_W-1:0]  addr
);
    localparam int SHIFT = $clog2(ENTRY_BYTES);
    localparam bit IS_POW2 = ((1 << SHIFT) == ENTRY_BYTES);

    generate
        if (IS_POW2) begin : g_shift
            // Scale the page number with a shift.
            always_comb addr = base + (PA_W'(vpn) << SHIFT);
        end else begin : g_mul
            // Scale the page number with a multiply.
            always_comb addr = base + PA_W'(vpn) * PA_W'(ENTRY_BYTES);
        end
    endgenerate
endmodule

// File: rtl/ptw_entry_check.sv
// Splits a fetched entry into its fields and judges the access against it.
// Assumes: valid at top bit, 3 permission bits below it, frame number in low bits.
module ptw_entry_check #(
    parameter int DATA_W = 32,
    parameter int PFN_W  = 20
) (
    input  logic [DATA_W-1:0] pte,
    input  logic [2:0]        need,
    output logic              pte_valid,
    output logic [2:0]        pte_perm,
    output logic [PFN_W-1:0]  pte_pfn,
    output logic              perm_ok
);
    localparam int VBIT = DATA_W - 1;
    localparam int PHI  = DATA_W - 2;
    localparam int PLO  = DATA_W - 4;

    // Field extraction and subset test of the needed rights.
    always_comb begin
        pte_valid = pte[VBIT];
        pte_perm  = pte[PHI:PLO];
        pte_pfn   = pte[PFN_W-1:0];
        perm_ok   = ((need & ~pte_perm) == 3'b000);
    end
endmodule

// File: rtl/ptw_walker.sv
// Single-level hardware page table walker: one read per miss, then
// insert+retry, segmentation fault or protection fault.
// Assumes: one walk at a time; memory returns exactly one response per request.
module ptw_walker #(
    parameter int PA_W        = 32,
    parameter int VPN_W       = 20,
    parameter int PFN_W       = 20,
    parameter int DATA_W      = 32,
    parameter int ENTRY_BYTES = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PA_W-1:0]   pt_base,
    input  logic              miss_valid,
    output logic              miss_ready,
    input  logic [VPN_W-1:0]  miss_vpn,
    input  logic [2:0]        miss_perm,
    output logic              rd_req_valid,
    input  logic              rd_req_ready,
    output logic [PA_W-1:0]   rd_req_addr,
    input  logic              rd_rsp_valid,
    input  logic [DATA_W-1:0] rd_rsp_data,
    output logic              ins_valid,
    output logic [VPN_W-1:0]  ins_vpn,
    output logic [PFN_W-1:0]  ins_pfn,
    output logic [2:0]        ins_perm,
    output logic              walk_done,
    output logic [1:0]        walk_status
);
    import ptw_pkg::*;

    walk_state_e       st_q, st_d;
    logic [VPN_W-1:0]  vpn_q;
    logic [2:0]        need_q;
    logic [PA_W-1:0]   addr_q;
    logic [DATA_W-1:0] pte_q;
    walk_status_e      status_q;

    logic [PA_W-1:0]   addr_calc;
    logic              e_valid;
    logic [2:0]        e_perm;
    logic [PFN_W-1:0]  e_pfn;
    logic              e_ok;

    ptw_addr_gen #(.PA_W(PA_W), .VPN_W(VPN_W), .ENTRY_BYTES(ENTRY_BYTES)) u_addr (
        .base (pt_base),
        .vpn  (miss_vpn),
        .addr (addr_calc)
    );

    ptw_entry_check #(.DATA_W(DATA_W), .PFN_W(PFN_W)) u_chk (
        .pte       (pte_q),
        .need      (need_q),
        .pte_valid (e_valid),
        .pte_perm  (e_perm),
        .pte_pfn   (e_pfn),
        .perm_ok   (e_ok)
    );

    // Next-state selection of the walk sequence.
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            S_IDLE:   if (miss_valid) st_d = S_ISSUE;
            S_ISSUE:  if (rd_req_ready) st_d = S_WAIT;
            S_WAIT:   if (rd_rsp_valid) st_d = S_CHECK;
            S_CHECK:  st_d = (e_valid && e_ok) ? S_INSERT : S_DONE;
            S_INSERT: st_d = S_DONE;
            S_DONE:   st_d = S_IDLE;
            default:  st_d = S_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_IDLE;
        else        st_q <= st_d;
    end

    // Capture of the miss and its entry address on acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpn_q  <= '0;
            need_q <= '0;
            addr_q <= '0;
        end else if (st_q == S_IDLE && miss_valid) begin
            vpn_q  <= miss_vpn;
            need_q <= miss_perm;
            addr_q <= addr_calc;
        end
    end

    // Capture of the fetched entry.
    always_ff @(posedge clk) begin
        if (!rst_n)                               pte_q <= '0;
        else if (st_q == S_WAIT && rd_rsp_valid)  pte_q <= rd_rsp_data;
    end

    // Verdict: valid bit first, then permissions.
    always_ff @(posedge clk) begin
        if (!rst_n) status_q <= WALK_RETRY;
        else if (st_q == S_CHECK) begin
            if (!e_valid)   status_q <= WALK_SEGV;
            else if (!e_ok) status_q <= WALK_PROT;
            else            status_q <= WALK_RETRY;
        end
    end

    // Output decode from state.
    always_comb begin
        miss_ready   = (st_q == S_IDLE);
        rd_req_valid = (st_q == S_ISSUE);
        rd_req_addr  = addr_q;
        ins_valid    = (st_q == S_INSERT);
        ins_vpn      = vpn_q;
        ins_pfn      = e_pfn;
        ins_perm     = e_perm;
        walk_done    = (st_q == S_DONE);
        walk_status  = status_q;
    end
endmodule

// File: rtl/ptw_walker_chk.sv
// Protocol checks for ptw_walker, attached with bind.
module ptw_walker_chk #(
    parameter int PA_W = 32
) (
    input logic            clk,
    input logic            rst_n,
    input logic            miss_valid,
    input logic            miss_ready,
    input logic            rd_req_valid,
    input logic            rd_req_ready,
    input logic [PA_W-1:0] rd_req_addr,
    input logic            ins_valid,
    input logic            walk_done,
    input logic [1:0]      walk_status
);
    // R2: a stalled request is held with the same address.
    a_r2_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr));
    // R2: one request per walk, dropped after it is taken.
    a_r2_single_req: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_valid && rd_req_ready |=> !rd_req_valid);
    // R5: insert is followed by a retry completion.
    a_r5_insert_then_retry: assert property (@(posedge clk) disable iff (!rst_n)
        ins_valid |=> walk_done && walk_status == 2'd0);
    // R6: completion strobe lasts one cycle.
    a_r6_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> !walk_done);
    // R6: status encoding is legal.
    a_r6_status_legal: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |-> walk_status != 2'd3);
    // R7: acceptance makes the walker busy.
    a_r7_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
        miss_valid && miss_ready |=> !miss_ready);
    // R7: completion returns the walker to idle.
    a_r7_idle_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        walk_done |=> miss_ready);
endmodule

bind ptw_walker ptw_walker_chk #(.PA_W(PA_W)) u_walker_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .miss_valid   (miss_valid),
    .miss_ready   (miss_ready),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .ins_valid    (ins_valid),
    .walk_done    (walk_done),
    .walk_status  (walk_status)
);

// File: tb/sim_ptw_walker.sv
// Scoreboard bench for ptw_walker.
module sim_ptw_walker;
    localparam int PA_W = 32, VPN_W = 20, PFN_W = 20, DATA_W = 32;

    typedef struct {
        logic [1:0]       status;
        logic [VPN_W-1:0] vpn;
        logic [PFN_W-1:0] pfn;
        logic [2:0]       perm;
    } exp_t;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [PA_W-1:0] pt_base = '0;
    logic miss_valid = 1'b0, miss_ready;
    logic [VPN_W-1:0] miss_vpn = '0;
    logic [2:0] miss_perm = '0;
    logic rd_req_valid, rd_req_ready = 1'b0;
    logic [PA_W-1:0] rd_req_addr;
    logic rd_rsp_valid = 1'b0;
    logic [DATA_W-1:0] rd_rsp_data = '0;
    logic ins_valid;
    logic [VPN_W-1:0] ins_vpn;
    logic [PFN_W-1:0] ins_pfn;
    logic [2:0] ins_perm;
    logic walk_done;
    logic [1:0] walk_status;

    int n_cmp = 0, n_bad = 0, cyc = 0;
    int stall_cyc = 0, lat_cyc = 0;
    logic [DATA_W-1:0] pte_mem [logic [PA_W-1:0]];
    exp_t exp_q[$];
    logic [PA_W-1:0] addr_q[$];
    bit ended = 0;

    always #4 clk = ~clk;

    ptw_walker u0 (.*);

    task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    // Memory model: checks the request address, applies stall and latency.
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req_valid) begin
                repeat (stall_cyc) begin
                    chk(rd_req_valid, "R2 request held during stall", rd_req_valid, 1);
                    @(negedge clk);
                end
                if (addr_q.size() == 0)
                    chk(0, "R7 unexpected read", rd_req_addr, 0);
                else begin
                    logic [PA_W-1:0] ea;
                    ea = addr_q.pop_front();
                    chk(rd_req_addr == ea, "R1 entry address", rd_req_addr, ea);
                end
                rd_req_ready = 1'b1;
                @(negedge clk);
                rd_req_ready = 1'b0;
                chk(!rd_req_valid, "R2 single read", rd_req_valid, 0);
                repeat (lat_cyc) @(negedge clk);
                rd_rsp_valid = 1'b1;
                rd_rsp_data  = pte_mem.exists(rd_req_addr) ? pte_mem[rd_req_addr] : '0;
                @(negedge clk);
                rd_rsp_valid = 1'b0;
                rd_rsp_data  = '0;
            end
        end
    end

    // Monitor: compares completions and inserts against the scoreboard.
    initial begin
        bit ins_seen = 0;
        int ins_cyc = 0;
        logic [VPN_W-1:0] iv;
        logic [PFN_W-1:0] ip;
        logic [2:0] ir;
        forever begin
            @(negedge clk);
            if (rst_n && ins_valid) begin
                ins_seen = 1; ins_cyc = cyc; iv = ins_vpn; ip = ins_pfn; ir = ins_perm;
            end
            if (rst_n && walk_done) begin
                if (exp_q.size() == 0) chk(0, "R6 unexpected completion", walk_status, 0);
                else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk(walk_status == e.status, "R3/R4/R5 status", walk_status, e.status);
                    if (e.status == 2'd0) begin
                        chk(ins_seen && (cyc - ins_cyc) == 1, "R5 insert one cycle before retry", ins_seen, 1);
                        chk(iv == e.vpn, "R5 insert vpn", iv, e.vpn);
                        chk(ip == e.pfn, "R9 insert pfn", ip, e.pfn);
                        chk(ir == e.perm, "R9 insert perm", ir, e.perm);
                    end else
                        chk(!ins_seen, "R3 R4 no insert on fault", ins_seen, 0);
                end
                ins_seen = 0;
                @(negedge clk);
                chk(!walk_done, "R6 done one cycle", walk_done, 0);
                chk(miss_ready, "R7 idle after done", miss_ready, 1);
            end
        end
    end

    // Driver: programs the entry, pushes expectations, offers the miss and waits.
    task automatic walk(input logic [PA_W-1:0] base, input logic [VPN_W-1:0] vpn,
                        input logic [2:0] need, input logic [DATA_W-1:0] pte,
                        input int stall, input int lat);
        exp_t e;
        logic [PA_W-1:0] a;
        logic [2:0] pp;
        a = base + {vpn, 2'b00};
        pp = pte[DATA_W-2:DATA_W-4];
        pte_mem[a] = pte;
        e.vpn = vpn; e.pfn = pte[PFN_W-1:0]; e.perm = pp;
        if (!pte[DATA_W-1])       e.status = 2'd1;
        else if ((need & ~pp) != 0) e.status = 2'd2;
        else                      e.status = 2'd0;
        exp_q.push_back(e);
        addr_q.push_back(a);
        stall_cyc = stall; lat_cyc = lat;
        @(negedge clk);
        while (!miss_ready) @(negedge clk);
        pt_base = base; miss_vpn = vpn; miss_perm = need; miss_valid = 1'b1;
        @(negedge clk);
        miss_valid = 1'b0;
        pt_base = 32'hDEAD_0000; miss_vpn = '1;
        while (exp_q.size() != 0) @(negedge clk);
        @(negedge clk);
    endtask

    function automatic logic [DATA_W-1:0] mk(input bit v, input logic [2:0] p, input logic [PFN_W-1:0] f);
        return {v, p, 8'h00, f};
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        // R8 reset state
        chk(miss_ready, "R8 miss_ready", miss_ready, 1);
        chk(!rd_req_valid && !ins_valid && !walk_done, "R8 outputs idle",
            {rd_req_valid, ins_valid, walk_done}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        walk(32'h0010_0000, 20'h12345, 3'b100, mk(1, 3'b100, 20'hABCDE), 0, 0); // R5 read allowed
        walk(32'h0010_0000, 20'h00042, 3'b111, mk(0, 3'b111, 20'h11111), 1, 2); // R3 invalid full perms
        walk(32'h0010_0000, 20'h00043, 3'b010, mk(1, 3'b100, 20'h22222), 0, 1); // R4 write to read-only
        walk(32'h0020_0000, 20'h00044, 3'b001, mk(1, 3'b111, 20'h33333), 3, 4); // R5 exec, R2 stall
        walk(32'h0020_0000, 20'h00045, 3'b110, mk(1, 3'b110, 20'h44444), 2, 0); // R5 rw ok
        walk(32'h0020_0000, 20'h00046, 3'b111, mk(1, 3'b110, 20'h55555), 0, 0); // R4 missing exec
        walk(32'h0000_1000, 20'h00000, 3'b000, mk(1, 3'b000, 20'h00001), 0, 0); // R1 vpn 0, R4 empty need
        walk(32'hFFFF_FFF0, 20'hFFFFF, 3'b100, mk(1, 3'b101, 20'hFFFFF), 0, 3); // R1 wrap
        walk(32'h0030_0000, 20'h00777, 3'b100, 32'hC0FF_F0F0 | mk(1, 3'b100, 20'h0F0F0), 0, 0); // R9 junk middle bits
        walk(32'h0030_0000, 20'h00778, 3'b100, 32'h70FF_FFFF, 0, 0); // R3/R9 invalid with junk

        // R7: offer a second miss while busy; it must not be taken.
        begin
            exp_t e;
            logic [PA_W-1:0] a;
            a = 32'h0040_0000 + {20'h00100, 2'b00};
            pte_mem[a] = mk(1, 3'b111, 20'h0ABCD);
            e.vpn = 20'h00100; e.pfn = 20'h0ABCD; e.perm = 3'b111; e.status = 2'd0;
            exp_q.push_back(e); addr_q.push_back(a);
            stall_cyc = 2; lat_cyc = 3;
            @(negedge clk);
            pt_base = 32'h0040_0000; miss_vpn = 20'h00100; miss_perm = 3'b100; miss_valid = 1'b1;
            @(negedge clk);
            miss_vpn = 20'h00200;
            for (int i = 0; i < 4; i++) begin
                chk(!miss_ready, "R7 busy refuses miss", miss_ready, 0);
                @(negedge clk);
            end
            miss_valid = 1'b0;
            while (exp_q.size() != 0) @(negedge clk);
            repeat (12) @(negedge clk);
            chk(addr_q.size() == 0, "R7 no extra read queued", addr_q.size(), 0);
        end

        repeat (5) @(negedge clk);
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        chk(0, "watchdog", cyc, 0);
        finish_run();
    end
endmodule